// File: doc/BRIEF.md
# Contrast-limited CDF table builder

This block converts one clipped tile histogram into the grey-level mapping table used for contrast-limited adaptive histogram equalization. It runs in the blanking gap between frames. A start pulse latches four per-tile figures from the accumulation stage: the clip limit, the number of in-range pixels, the count that overflowed the limit, and the number of bins that reached the limit. The block then reads the histogram store once, bin by bin, and writes one table entry per bin.

The overflow is shared out in a single step. Only the bins that never reached the limit count toward the divisor. Every bin gets the same share, and the result is clipped to the limit again. Anything that still exceeds the limit is dropped and is not redistributed a second time. The clipped bins form a running sum, and that sum is scaled to the output code range. Both divisions (the share and the normalization) become multiplications by reciprocals. A restoring divider works these reciprocals out once, before the pass starts.

Top module: `clip_cdf_lut`

## Requirements
- R1: While reset is held and right after it, hist_re_o, lut_we_o, busy_o and done_o are all 0.
- R2: A start_i pulse accepted while idle leads to exactly NB = 4·2^OUT_W table writes (64 by default). The writes go to addresses 0 up to NB−1 in ascending order, on consecutive cycles, and each read of the store is issued while busy_o is 1.
- R3: The share per bin is floor(excess·floor(2^FRAC_W/R)/2^FRAC_W), where R = NB − sat_bins is the number of receiving bins. The share is 0 when sat_bins ≥ NB.
- R4: Each bin value is min(stored count + share, clip limit). The part above the limit is discarded. This means a bin already at the limit contributes exactly the limit.
- R5: The entry at address a is min(2^OUT_W−1, floor(S·(2^OUT_W−1)·floor(2^FRAC_W/P)/2^FRAC_W)). Here S is the sum of the clipped values of bins 0..a, and P is the latched pixel count. When P is 0, every entry is 0.
- R6: The store has one cycle of read latency. The write for address a appears exactly two cycles after the cycle in which address a was read.
- R7: done_o is a one-cycle pulse in the same cycle as the write to address NB−1. busy_o is 0 in the cycle after it.
- R8: A start_i pulse while busy_o is 1 is ignored. It does not change the latched figures and does not restart the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin building a table (one-cycle pulse) |
| clip_limit_i | input | BIN_W (8) | Clip limit for the tile |
| pix_cnt_i | input | CNT_W (12) | In-range pixel count of the tile |
| excess_i | input | CNT_W (12) | Count that overflowed the limit during accumulation |
| sat_bins_i | input | AW+1 (7) | Number of bins that reached the limit |
| hist_re_o | output | 1 | Histogram store read enable |
| hist_raddr_o | output | AW (6) | Histogram store read address |
| hist_rdata_i | input | BIN_W (8) | Histogram store read data, one cycle after the read |
| lut_we_o | output | 1 | Table write strobe |
| lut_waddr_o | output | AW (6) | Table write address |
| lut_wdata_o | output | OUT_W (4) | Table write data |
| busy_o | output | 1 | Table build in progress |
| done_o | output | 1 | Last table entry written |

## Verification
The assertions assume that the histogram store returns data exactly one cycle after each read, and that start_i is a single-cycle pulse. They also assume the four tile figures do not need to hold once the start pulse has been taken. The bench models the store as a registered array and changes it only while the block is idle. It drives start_i for exactly one cycle and keeps the pixel count, excess and clip limit within their port widths. In one run it deliberately pulses start_i with different figures in the middle of a pass, to show that the latched values are kept.

// File: rtl/clip_cdf_pkg.sv
package clip_cdf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_DIV,
    ST_SHARE,
    ST_PASS,
    ST_WAIT
  } phase_e;
endpackage

// File: rtl/recip_div.sv
// Restoring divider: recip_o = floor(2^FW / div_i), 0 when div_i is 0.
module recip_div #(
  parameter int DW = 12,
  parameter int FW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] div_i,
  output logic          busy_o,
  output logic [FW:0]   recip_o
);
  localparam int CW = $clog2(FW + 1);

  logic [DW-1:0] rem_q;
  logic [FW:0]   quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   trial;
  logic          ge;

  assign trial = {rem_q, (cnt_q == CW'(FW))};
  assign ge    = trial >= {1'b0, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= CW'(FW);
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= ge ? DW'(trial - {1'b0, div_i}) : trial[DW-1:0];
      quo_q <= {quo_q[FW-1:0], ge};
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = run_q;
  assign recip_o = (div_i == '0) ? '0 : quo_q;
endmodule

// File: rtl/cdf_norm.sv
// Scales a running sum to the output code range through a reciprocal.
module cdf_norm #(
  parameter int SUM_W  = 14,
  parameter int OUT_W  = 4,
  parameter int FRAC_W = 16
) (
  input  logic [SUM_W-1:0]  sum_i,
  input  logic [FRAC_W:0]   recip_i,
  output logic [OUT_W-1:0]  code_o
);
  localparam int PW = SUM_W + OUT_W + FRAC_W + 1;
  localparam logic [PW-1:0] CODE_MAX = PW'((1 << OUT_W) - 1);

  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;

  always_comb begin
    prod   = PW'(sum_i) * CODE_MAX * PW'(recip_i);
    scaled = prod >> FRAC_W;
    code_o = (scaled > CODE_MAX) ? CODE_MAX[OUT_W-1:0] : scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/clip_cdf_lut.sv
module clip_cdf_lut
  import clip_cdf_pkg::*;
#(
  parameter int OUT_W  = 4,
  parameter int BIN_W  = 8,
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 16,
  localparam int NB    = 4 * (2 ** OUT_W),
  localparam int AW    = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIN_W-1:0] clip_limit_i,
  input  logic [CNT_W-1:0] pix_cnt_i,
  input  logic [CNT_W-1:0] excess_i,
  input  logic [AW:0]      sat_bins_i,
  output logic             hist_re_o,
  output logic [AW-1:0]    hist_raddr_o,
  input  logic [BIN_W-1:0] hist_rdata_i,
  output logic             lut_we_o,
  output logic [AW-1:0]    lut_waddr_o,
  output logic [OUT_W-1:0] lut_wdata_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int SUM_W = BIN_W + AW;
  localparam int RW    = FRAC_W + 1;
  localparam int SW    = CNT_W + 1;
  localparam int MW    = CNT_W + RW;
  localparam logic [AW-1:0] LAST = AW'(NB - 1);

  phase_e state_q;
  logic [BIN_W-1:0] lim_q;
  logic [CNT_W-1:0] pcnt_q, exc_q, share_q;
  logic [AW:0]      sat_q, recv;
  logic [AW-1:0]    raddr_q, rd_addr_q, waddr_q;
  logic             rd_vld_q, we_q, done_q;
  logic [SUM_W-1:0] sum_q, sum_nx;
  logic [OUT_W-1:0] wdata_q, code;
  logic [SW-1:0]    bin_sum;
  logic [BIN_W-1:0] clipped;
  logic [MW-1:0]    sh_prod;
  logic             start_ok, div_busy;

  logic [CNT_W-1:0] dvs   [2];
  logic [RW-1:0]    recip [2];
  logic [1:0]       dbusy;

  // index 0: share divisor (receiving bins), index 1: pixel count
  assign recv   = (sat_q >= (AW+1)'(NB)) ? '0 : (AW+1)'(NB) - sat_q;
  assign dvs[0] = CNT_W'(recv);
  assign dvs[1] = pcnt_q;

  for (genvar g = 0; g < 2; g++) begin : g_recip
    recip_div #(.DW(CNT_W), .FW(FRAC_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (state_q == ST_KICK),
      .div_i   (dvs[g]),
      .busy_o  (dbusy[g]),
      .recip_o (recip[g])
    );
  end
  assign div_busy = |dbusy;

  assign sh_prod  = MW'(exc_q) * MW'(recip[0]);
  assign bin_sum  = SW'(hist_rdata_i) + SW'(share_q);
  assign clipped  = (bin_sum > SW'(lim_q)) ? lim_q : bin_sum[BIN_W-1:0];
  assign sum_nx   = sum_q + SUM_W'(clipped);

  cdf_norm #(.SUM_W(SUM_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_norm (
    .sum_i   (sum_nx),
    .recip_i (recip[1]),
    .code_o  (code)
  );

  assign start_ok = (state_q == ST_IDLE) && !we_q && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lim_q   <= '0;
      pcnt_q  <= '0;
      exc_q   <= '0;
      sat_q   <= '0;
      share_q <= '0;
      raddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ok) begin
          lim_q   <= clip_limit_i;
          pcnt_q  <= pix_cnt_i;
          exc_q   <= excess_i;
          sat_q   <= sat_bins_i;
          state_q <= ST_KICK;
        end
        ST_KICK:  state_q <= ST_DIV;
        ST_DIV:   if (!div_busy) state_q <= ST_SHARE;
        ST_SHARE: begin
          share_q <= sh_prod[FRAC_W +: CNT_W];
          raddr_q <= '0;
          state_q <= ST_PASS;
        end
        ST_PASS: begin
          raddr_q <= raddr_q + 1'b1;
          if (raddr_q == LAST) state_q <= ST_WAIT;
        end
        ST_WAIT: if (rd_vld_q && rd_addr_q == LAST) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read-data stage, matched to the one-cycle store latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      sum_q     <= '0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      rd_vld_q  <= (state_q == ST_PASS);
      rd_addr_q <= raddr_q;
      if (state_q == ST_SHARE) sum_q <= '0;
      else if (rd_vld_q)       sum_q <= sum_nx;
      we_q   <= rd_vld_q;
      done_q <= rd_vld_q && (rd_addr_q == LAST);
      if (rd_vld_q) begin
        waddr_q <= rd_addr_q;
        wdata_q <= code;
      end
    end
  end

  assign hist_re_o    = (state_q == ST_PASS);
  assign hist_raddr_o = raddr_q;
  assign lut_we_o     = we_q;
  assign lut_waddr_o  = waddr_q;
  assign lut_wdata_o  = wdata_q;
  assign done_o       = done_q;
  assign busy_o       = (state_q != ST_IDLE) || we_q;
endmodule

// File: rtl/clip_cdf_lut_chk.sv
module clip_cdf_lut_chk #(
  parameter int AW    = 6,
  parameter int OUT_W = 4,
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hist_re_o,
  input logic [AW-1:0]    hist_raddr_o,
  input logic             lut_we_o,
  input logic [AW-1:0]    lut_waddr_o,
  input logic [OUT_W-1:0] lut_wdata_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] pcnt
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  a_r6_write_two_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_we_o |-> ($past(hist_re_o, 2) && lut_waddr_o == $past(hist_raddr_o, 2)));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lut_we_o && lut_waddr_o != LAST) |=> (lut_we_o && lut_waddr_o == $past(lut_waddr_o) + 1'b1));

  a_r2_read_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_re_o |-> busy_o);

  a_r7_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lut_we_o && lut_waddr_o == LAST));

  a_r7_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !lut_we_o && !done_o));

  a_r5_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lut_we_o && pcnt == '0) |-> lut_wdata_o == '0);
endmodule

bind clip_cdf_lut clip_cdf_lut_chk #(.AW(AW), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hist_re_o    (hist_re_o),
  .hist_raddr_o (hist_raddr_o),
  .lut_we_o     (lut_we_o),
  .lut_waddr_o  (lut_waddr_o),
  .lut_wdata_o  (lut_wdata_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pcnt         (pcnt_q)
);

// File: tb/clip_cdf_lut_test.sv
module clip_cdf_lut_test;
  localparam int OUT_W = 4, BIN_W = 8, CNT_W = 12, FRAC_W = 16;
  localparam int NB = 4 * (2 ** OUT_W), AW = $clog2(NB);
  localparam int CMAX = (1 << OUT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [BIN_W-1:0] lim = '0;
  logic [CNT_W-1:0] pcnt = '0, exc = '0;
  logic [AW:0] sat = '0;
  logic hist_re, lut_we, busy, done;
  logic [AW-1:0] raddr, waddr;
  logic [BIN_W-1:0] rdata = '0;
  logic [OUT_W-1:0] wdata;
  logic [BIN_W-1:0] mem [NB];

  int vectors = 0, miscompares = 0, dones = 0;
  int exp_q[$];
  string tag_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  clip_cdf_lut uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .clip_limit_i(lim), .pix_cnt_i(pcnt), .excess_i(exc), .sat_bins_i(sat),
    .hist_re_o(hist_re), .hist_raddr_o(raddr), .hist_rdata_i(rdata),
    .lut_we_o(lut_we), .lut_waddr_o(waddr), .lut_wdata_o(wdata),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) if (hist_re) rdata <= mem[raddr];

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected entries as the design writes them
  always @(negedge clk) if (rst_ni) begin
    if (done) dones++;
    if (lut_we) begin
      if (exp_q.size() == 0) check("R8 unexpected write", 1, 0);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({"R2 address ", t}, longint'(waddr), longint'(e >> 16));
        check(t, longint'(wdata), longint'(e & 16'hffff));
      end
    end
  end

  function automatic longint recip(input longint d);
    return (d == 0) ? 0 : (longint'(1) << FRAC_W) / d;
  endfunction

  task automatic run_tile(input int l, input int pc, input int ex, input int sb,
                          input int mode, input string tag, input bit poke);
    longint share, s, r, c, p;
    int start_dones;
    p = 0;
    for (int i = 0; i < NB; i++) begin
      case (mode)
        0: mem[i] = BIN_W'((i * 3) % 50);
        1: mem[i] = BIN_W'((i * 7) % 25 > l ? l : (i * 7) % 25);
        2: mem[i] = BIN_W'(l);
        default: mem[i] = BIN_W'((i % 5 == 0) ? l : i % 4);
      endcase
      p += mem[i];
    end
    if (pc < 0) pc = int'(p) + ex;
    r = (sb >= NB) ? 0 : NB - sb;
    share = (longint'(ex) * recip(r)) >> FRAC_W;
    s = 0;
    for (int i = 0; i < NB; i++) begin
      c = mem[i] + share;
      if (c > l) c = l;
      s += c;
      c = (s * CMAX * recip(pc)) >> FRAC_W;
      if (c > CMAX) c = CMAX;
      exp_q.push_back((i << 16) | int'(c));
      tag_q.push_back(tag);
    end
    start_dones = dones;
    @(negedge clk);
    lim = BIN_W'(l); pcnt = CNT_W'(pc); exc = CNT_W'(ex); sat = (AW+1)'(sb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = '0; pcnt = '0; exc = '0; sat = '0;
    if (poke) begin
      repeat (30) @(negedge clk);
      lim = 8'd3; pcnt = 12'd7; exc = 12'd900; sat = '0;
      start = 1'b1;  // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check({"R7 single done ", tag}, dones - start_dones, 1);
    check({"R7 busy after done ", tag}, longint'(busy), 0);
    check({"R2 all entries written ", tag}, exp_q.size(), 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      check("R8 no restart", longint'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hist_re in reset", longint'(hist_re), 0);
    check("R1 lut_we in reset", longint'(lut_we), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", longint'(busy), 0);
    check("R1 done after reset", longint'(done), 0);
    run_tile(255, -1, 0, 0, 0, "R5 ramp", 0);
    run_tile(20, -1, 300, 10, 1, "R4 clip with share", 0);
    run_tile(9, -1, 500, 64, 2, "R3 no receivers", 0);
    run_tile(9, -1, 500, 70, 3, "R3 oversized count", 0);
    run_tile(12, 0, 200, 13, 3, "R5 zero pixel count", 0);
    run_tile(40, 150, 600, 13, 3, "R5 saturated codes", 0);
    run_tile(30, -1, 450, 20, 1, "R8 start while busy", 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule